// File: doc/BRIEF.md
# Multi-Port Register File with Per-Port Read Timing

This block is a small storage array built from flip-flops. Several write ports share one write clock. Several read ports each take their own address. Each read port is set up on its own, at elaboration, in one of two ways. It can be a plain combinational lookup, or it can be a registered lookup. A registered lookup captures on either the rising or the falling edge of its own clock.

A rising-edge registered port also selects what it returns when it reads a word in the same cycle that a write port updates that word. It returns either the incoming value or the value held before the write. For this forwarding to be meaningful, the port's clock must be the write clock itself. A falling-edge port always samples whatever the array holds at that edge.

When two write ports hit one address together, the higher-numbered port wins. An asynchronous active-low reset clears every word and every read register.

Top module: `mport_regfile`

## Requirements
- R1: A read port whose RD_CLOCKED bit is 0 drives the word at its address combinationally: a change of address or array contents shows on its output with no clock edge, and its clock input has no effect.
- R2: On a rising wclk edge, a write port with its enable high stores its data at its address. With no enable high, the array keeps every word unchanged.
- R3: When more than one enabled write port targets one address in the same cycle, the word takes the data of the highest-numbered of them.
- R4: A registered port with RD_RISING bit 1 updates its output only on the rising edge of its clock. Between edges, the output holds even if the address changes.
- R5: A registered port with RD_RISING bit 0 captures the array word at its address on the falling edge of its clock.
- R6: A rising-edge port with RD_NEWDATA bit 1 that reads an address being written in the same cycle (read clock tied to wclk) outputs the data being written.
- R7: A rising-edge port with RD_NEWDATA bit 0 in the same situation outputs the word held before the write.
- R8: On a falling-edge port the RD_NEWDATA bit has no effect: the port returns the array contents at the falling edge.
- R9: While rst_n is low, every word reads as zero and every registered output is zero. An address never written since reset reads as zero.
- R10: New-data forwarding follows the same priority as the array: with several enabled writes to the read address, the forwarded value is that of the highest-numbered write port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock, rising edge, shared by all write ports |
| rst_n | input | 1 | Asynchronous active-low reset of array and read registers |
| wr_en | input | WR_PORTS | Per write port enable |
| wr_addr | input | WR_PORTS*ADDR_W | Write addresses, port k in bits [k*ADDR_W +: ADDR_W] |
| wr_data | input | WR_PORTS*DATA_W | Write data, port k in bits [k*DATA_W +: DATA_W] |
| rd_clk | input | RD_PORTS | Per read port clock (ignored on combinational ports) |
| rd_addr | input | RD_PORTS*ADDR_W | Read addresses, port k in bits [k*ADDR_W +: ADDR_W] |
| rd_data | output | RD_PORTS*DATA_W | Read data, port k in bits [k*DATA_W +: DATA_W] |

## Verification
The bench uses the default build: five read ports and two write ports, with an 8-bit data width and 8 words at a 3-bit address. Read port 0 is combinational. Ports 1 and 2 capture on the rising edge, port 1 forwarding new data and port 2 returning old data. Ports 3 and 4 capture on the falling edge, with the forwarding bit set and cleared. This one build exercises every timing and transparency combination against a behavioural array. The two write ports make same-address collisions possible, which covers both array priority and forwarding priority. Because the depth fills the address space, reads of never-written words also fall within reach.

// File: rtl/rf_pkg.sv
`timescale 1ns/1ps
package rf_pkg;
  typedef enum logic [1:0] {RD_COMB, RD_RISE, RD_FALL} rd_mode_e;

  function automatic rd_mode_e pick_mode(input logic clocked, input logic rising);
    if (!clocked) return RD_COMB;
    return rising ? RD_RISE : RD_FALL;
  endfunction
endpackage

// File: rtl/rf_array.sv
`timescale 1ns/1ps
module rf_array #(
  parameter int WR_PORTS = 2,
  parameter int ADDR_W   = 3,
  parameter int DATA_W   = 8,
  parameter int DEPTH    = 8
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [WR_PORTS-1:0]                wr_en,
  input  logic [WR_PORTS-1:0][ADDR_W-1:0]    wr_addr,
  input  logic [WR_PORTS-1:0][DATA_W-1:0]    wr_data,
  output logic [DEPTH-1:0][DATA_W-1:0]       words
);
  localparam int TOP = WR_PORTS - 1;

  // Later loop iterations override earlier ones: highest port wins.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      words <= '0;
    end else begin
      for (int w = 0; w < WR_PORTS; w++) begin
        if (wr_en[w] && (32'(wr_addr[w]) < DEPTH))
          words[wr_addr[w]] <= wr_data[w];
      end
    end
  end

  assert_top_port_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en[TOP] && (32'(wr_addr[TOP]) < DEPTH)) |=>
      (words[$past(wr_addr[TOP])] == $past(wr_data[TOP])));

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en == '0) |=> $stable(words));
endmodule

// File: rtl/rf_read_port.sv
`timescale 1ns/1ps
module rf_read_port
  import rf_pkg::*;
#(
  parameter int   WR_PORTS = 2,
  parameter int   ADDR_W   = 3,
  parameter int   DATA_W   = 8,
  parameter int   DEPTH    = 8,
  parameter logic CLOCKED  = 1'b1,
  parameter logic RISING   = 1'b1,
  parameter logic NEWDATA  = 1'b0
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [ADDR_W-1:0]                  addr,
  input  logic [DEPTH-1:0][DATA_W-1:0]       words,
  input  logic [WR_PORTS-1:0]                wr_en,
  input  logic [WR_PORTS-1:0][ADDR_W-1:0]    wr_addr,
  input  logic [WR_PORTS-1:0][DATA_W-1:0]    wr_data,
  output logic [DATA_W-1:0]                  data
);
  localparam rd_mode_e MODE = pick_mode(CLOCKED, RISING);
  localparam int TOP = WR_PORTS - 1;

  logic              in_range;
  logic [DATA_W-1:0] arr_word;
  logic              fwd_hit;
  logic [DATA_W-1:0] fwd_val;
  logic [DATA_W-1:0] next_val;
  wire unused_sig = ^{clk, rst_n, wr_en, wr_addr, wr_data, fwd_hit, fwd_val, next_val};

  assign in_range = 32'(addr) < DEPTH;
  assign arr_word = in_range ? words[addr] : '0;

  always_comb begin
    fwd_hit = 1'b0;
    fwd_val = '0;
    for (int w = 0; w < WR_PORTS; w++) begin
      if (wr_en[w] && (wr_addr[w] == addr) && in_range) begin
        fwd_hit = 1'b1;
        fwd_val = wr_data[w];
      end
    end
  end

  assign next_val = (NEWDATA && fwd_hit) ? fwd_val : arr_word;

  generate
    if (MODE == RD_COMB) begin : g_comb
      assign data = arr_word;
    end else if (MODE == RD_RISE) begin : g_rise
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) data <= '0;
        else        data <= next_val;
      end
      if (NEWDATA) begin : g_new_chk
        assert_newdata_R6: assert property (@(posedge clk) disable iff (!rst_n)
          (wr_en[TOP] && (wr_addr[TOP] == addr) && in_range) |=>
            (data == $past(wr_data[TOP])));
      end else begin : g_old_chk
        assert_olddata_R7: assert property (@(posedge clk) disable iff (!rst_n)
          (wr_en[0] && (wr_addr[0] == addr) && in_range) |=>
            (data == $past(words[addr])));
      end
    end else begin : g_fall
      always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) data <= '0;
        else        data <= arr_word;
      end
      assert_fall_samples_R5: assert property (@(negedge clk) disable iff (!rst_n)
        in_range |=> (data == $past(words[addr])));
    end
  endgenerate
endmodule

// File: rtl/mport_regfile.sv
`timescale 1ns/1ps
module mport_regfile #(
  parameter int                RD_PORTS   = 5,
  parameter int                WR_PORTS   = 2,
  parameter int                ADDR_W     = 3,
  parameter int                DATA_W     = 8,
  parameter int                DEPTH      = 8,
  parameter logic [RD_PORTS-1:0] RD_CLOCKED = 5'b11110,
  parameter logic [RD_PORTS-1:0] RD_RISING  = 5'b00110,
  parameter logic [RD_PORTS-1:0] RD_NEWDATA = 5'b01010
) (
  input  logic                         wclk,
  input  logic                         rst_n,
  input  logic [WR_PORTS-1:0]          wr_en,
  input  logic [WR_PORTS*ADDR_W-1:0]   wr_addr,
  input  logic [WR_PORTS*DATA_W-1:0]   wr_data,
  input  logic [RD_PORTS-1:0]          rd_clk,
  input  logic [RD_PORTS*ADDR_W-1:0]   rd_addr,
  output logic [RD_PORTS*DATA_W-1:0]   rd_data
);
  logic [WR_PORTS-1:0][ADDR_W-1:0] wa;
  logic [WR_PORTS-1:0][DATA_W-1:0] wd;
  logic [DEPTH-1:0][DATA_W-1:0]    words;

  assign wa = wr_addr;
  assign wd = wr_data;

  rf_array #(
    .WR_PORTS(WR_PORTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)
  ) u_array (
    .clk(wclk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wa), .wr_data(wd), .words(words)
  );

  for (genvar r = 0; r < RD_PORTS; r++) begin : g_rd
    rf_read_port #(
      .WR_PORTS(WR_PORTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH),
      .CLOCKED(RD_CLOCKED[r]), .RISING(RD_RISING[r]), .NEWDATA(RD_NEWDATA[r])
    ) u_port (
      .clk(rd_clk[r]), .rst_n(rst_n), .addr(rd_addr[r*ADDR_W +: ADDR_W]),
      .words(words), .wr_en(wr_en), .wr_addr(wa), .wr_data(wd),
      .data(rd_data[r*DATA_W +: DATA_W])
    );
  end
endmodule

// File: tb/sim_mport_regfile.sv
`timescale 1ns/1ps
module sim_mport_regfile;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] wr_en = '0;
  logic [2:0] wa0 = '0, wa1 = '0, ra = '0;
  logic [7:0] wd0 = '0, wd1 = '0;
  logic [39:0] rd_data;
  logic [7:0] model [8];
  int total = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mport_regfile u0 (
    .wclk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr({wa1, wa0}),
    .wr_data({wd1, wd0}), .rd_clk({5{clk}}), .rd_addr({5{ra}}), .rd_data(rd_data)
  );

  function automatic logic [7:0] port(input int p);
    return rd_data[p*8 +: 8];
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic we0; logic [2:0] a0; logic [7:0] d0;
    logic we1; logic [2:0] a1; logic [7:0] d1;
    logic [2:0] ra; logic [7:0] exp_new; logic [7:0] exp_old;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VT [NV] = '{
    '{1'b1, 3'd2, 8'h11, 1'b0, 3'd0, 8'h00, 3'd2, 8'h11, 8'h00},
    '{1'b0, 3'd0, 8'h00, 1'b1, 3'd5, 8'h22, 3'd2, 8'h11, 8'h11},
    '{1'b1, 3'd5, 8'h33, 1'b1, 3'd5, 8'h44, 3'd5, 8'h44, 8'h22},
    '{1'b1, 3'd7, 8'h55, 1'b0, 3'd0, 8'h00, 3'd7, 8'h55, 8'h00},
    '{1'b0, 3'd2, 8'hFF, 1'b0, 3'd2, 8'hEE, 3'd2, 8'h11, 8'h11},
    '{1'b1, 3'd3, 8'h66, 1'b1, 3'd4, 8'h77, 3'd4, 8'h77, 8'h00},
    '{1'b0, 3'd0, 8'h00, 1'b0, 3'd0, 8'h00, 3'd3, 8'h66, 8'h66},
    '{1'b1, 3'd0, 8'hA5, 1'b0, 3'd0, 8'h00, 3'd6, 8'h00, 8'h00},
    '{1'b1, 3'd0, 8'hC3, 1'b1, 3'd0, 8'h5A, 3'd0, 8'h5A, 8'hA5}
  };

  initial begin
    #100000;
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    for (int p = 0; p < 5; p++) chk("R9 reset output", port(p), 8'h00);
    rst_n = 1'b1;
    @(posedge clk); #1;
    ra = 3'd6;
    #0.5 chk("R9 unwritten comb", port(0), 8'h00);
    @(posedge clk); #1;

    for (int i = 0; i < NV; i++) begin
      wr_en = {VT[i].we1, VT[i].we0};
      wa0 = VT[i].a0; wd0 = VT[i].d0; wa1 = VT[i].a1; wd1 = VT[i].d1;
      ra = VT[i].ra;
      #0.5 chk("R1 comb before write", port(0), model[ra]);
      @(negedge clk); #0.5;
      chk("R8 fall port new-data bit set", port(3), model[ra]);
      chk("R5 fall port", port(4), model[ra]);
      @(posedge clk); #1;
      chk("R6 R10 rise new-data", port(1), VT[i].exp_new);
      chk("R7 rise old-data", port(2), VT[i].exp_old);
      if (VT[i].we0) model[VT[i].a0] = VT[i].d0;
      if (VT[i].we1) model[VT[i].a1] = VT[i].d1;
      chk("R2 R3 comb after write", port(0), model[ra]);
    end
    wr_en = '0;

    // R4: rising ports hold across an address change until the next edge
    ra = 3'd5;
    #0.5;
    chk("R1 comb follows address", port(0), 8'h44);
    chk("R4 hold new-data port", port(1), 8'h5A);
    chk("R4 hold old-data port", port(2), 8'hA5);
    @(posedge clk); #1;
    chk("R4 update on edge", port(1), 8'h44);
    chk("R4 update on edge old", port(2), 8'h44);
    ra = 3'd4;
    @(negedge clk); #0.5;
    chk("R5 fall capture", port(4), 8'h77);
    chk("R8 fall capture", port(3), 8'h77);

    // R2: disabled write leaves the word unchanged
    @(posedge clk); #1;
    wa0 = 3'd4; wd0 = 8'hBD; wr_en = 2'b00;
    @(posedge clk); #1;
    chk("R2 disabled write ignored", port(0), 8'h77);

    // R9: mid-run reset clears array and registers
    rst_n = 1'b0;
    #0.5;
    for (int p = 0; p < 5; p++) chk("R9 mid-run reset", port(p), 8'h00);
    @(posedge clk); #1;
    rst_n = 1'b1;
    ra = 3'd3;
    #0.5 chk("R9 array cleared", port(0), 8'h00);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule